// File: doc/BRIEF.md
# Low-Speed SDRAM Controller

This block drives one single-data-rate SDRAM device or module from a plain request/acknowledge port. It is meant for a slow clock and a low-bandwidth sequential store, such as a buffer that takes in video a word at a time. A client asks for one word, either a read or a write. The controller opens the row, issues the column access with auto-precharge, and then holds the bus quiet until the bank is closed again. Only one row is ever open.

After reset the controller runs the whole power-up sequence by itself. It also raises refresh on a fixed schedule and slots each refresh in between client accesses. Every delay is a fixed cycle count set for the worst part the system is expected to take, so no timing data is read from the module. Registered modules put a register stage on command, address and write data alike. They are handled with a single parameter, which adds one cycle to the read return path and to the post-access gap.

Top module: `sdram_lite_ctrl`

## Requirements
- R1: While reset is held, the command pins `{sd_cs_n,sd_ras_n,sd_cas_n,sd_we_n}` show NOP (4'b0111), `sd_cke`, `ack`, `rvalid` and `sd_dq_oe` are 0; command codes are MRS 0000, REF 0001, PRE 0010, ACT 0011, WRITE 0100, READ 0101.
- R2: After reset release the first commands are, in order and with nothing else between: PRE with `sd_addr[10]`=1, REF, REF, MRS; the PRE appears no sooner than T_POWERUP cycles after release.
- R3: The MRS command carries bank 0 and `sd_addr` equal to CAS_LAT in bits 6:4 with every other bit 0 (burst length one, sequential).
- R4: The user address splits as {bank, row, column} from MSB to LSB; ACT carries bank and row, and READ or WRITE follows exactly T_RCD cycles later on the same bank, with the column in the low `sd_addr` bits and `sd_addr[10]`=1 (auto-precharge).
- R5: `ack` is a one-cycle pulse in the cycle the ACT command is on the pins; the client holds `req`, `req_we`, `req_addr`, `req_wdata` until it.
- R6: `sd_dq_oe` is high exactly in the WRITE command cycle, with `sd_dq_out` equal to the accepted write data.
- R7: For a read, `rvalid` pulses for one cycle CAS_LAT+REG_EXTRA+1 cycles after the READ command cycle, with `rdata` holding the word present on `sd_dq_in` in the cycle before.
- R8: After READ or WRITE, no command follows for at least T_WR+T_RP+CAS_LAT+REG_EXTRA cycles.
- R9: With no client traffic, successive REF commands are exactly REF_INTERVAL cycles apart.
- R10: When a refresh falls due during an access and a new request is already waiting, the REF is issued before the waiting request's ACT.
- R11: After any REF, no command follows for at least T_RFC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Client request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | BANK_W+SA_W+COL_W | Word address {bank,row,column} |
| req_wdata | input | DATA_W | Write data |
| ack | output | 1 | Request accepted (ACT issued) |
| rdata | output | DATA_W | Read data |
| rvalid | output | 1 | Read data strobe |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | SA_W | Multiplexed row/column address |
| sd_dq_out | output | DATA_W | Write data to the memory |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dq_in | input | DATA_W | Read data from the memory |

## Verification
The bench builds the controller with CAS_LAT=2 and REG_EXTRA=1, which makes the read return path three stages deep. A mistimed capture stage would show up as a one-cycle shift of `rvalid`. T_POWERUP is cut to 20 and REF_INTERVAL to 60 so that the initialization sequence and several refreshes fit in a short run. With the interval that short, refresh also lands inside client traffic. The bench predicts the next refresh from an observed idle one and launches an access to straddle it, which makes the refresh-versus-request contention deterministic.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  // SDRAM command encoding on {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [3:0] {
    ST_WAIT,
    ST_INIT_PRE,
    ST_INIT_REF1,
    ST_INIT_REF2,
    ST_INIT_MRS,
    ST_IDLE,
    ST_ACT,
    ST_RW,
    ST_REF
  } seq_state_e;

endpackage

// File: rtl/sdc_refresh_timer.sv
module sdc_refresh_timer #(
  parameter int INTERVAL = 520
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic grant,
  output logic pending
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          tick;

  always_comb begin
    cnt_d = cnt_q;
    tick  = 1'b0;
    if (run) begin
      if (cnt_q == CW'(INTERVAL - 1)) begin
        cnt_d = '0;
        tick  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    // a new tick wins over a grant in the same cycle
    if (tick)       pend_d = 1'b1;
    else if (grant) pend_d = 1'b0;
    else            pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;

endmodule

// File: rtl/sdc_read_return.sv
module sdc_read_return #(
  parameter int DATA_W = 16,
  parameter int LAT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_issued,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);
  logic [LAT-1:0]    pipe_q;
  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  for (genvar i = 0; i < LAT; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[0] <= 1'b0;
        else        pipe_q[0] <= rd_issued;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[i] <= 1'b0;
        else        pipe_q[i] <= pipe_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= pipe_q[LAT-1];
      if (pipe_q[LAT-1]) rdata_q <= dq_in;
    end
  end

  assign rvalid = rvalid_q;
  assign rdata  = rdata_q;

endmodule

// File: rtl/sdc_sequencer.sv
module sdc_sequencer
  import sdc_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int SA_W      = 12,
  parameter int COL_W     = 8,
  parameter int DATA_W    = 16,
  parameter int CAS_LAT   = 2,
  parameter int REG_EXTRA = 0,
  parameter int T_RCD     = 2,
  parameter int T_RP      = 2,
  parameter int T_WR      = 2,
  parameter int T_RFC     = 7,
  parameter int T_MRD     = 2,
  parameter int T_POWERUP = 6600,
  localparam int ADDR_W   = BANK_W + SA_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ref_pending,
  output logic              ref_grant,
  output logic              ready,
  output logic              ack,
  output sd_cmd_e           cmd,
  output logic [BANK_W-1:0] sd_ba,
  output logic [SA_W-1:0]   sd_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              cke
);
  localparam int POST  = T_WR + T_RP + CAS_LAT + REG_EXTRA;
  localparam int MAXD  = (T_POWERUP > POST) ? T_POWERUP : POST;
  localparam int CNT_W = $clog2(MAXD + 1);
  localparam logic [SA_W-1:0] MODE_WORD = SA_W'(CAS_LAT << 4);
  localparam int AP_BIT = 10;

  seq_state_e        state_q, state_d, ret_q, ret_d, target;
  logic [CNT_W-1:0]  wcnt_q, wcnt_d;
  sd_cmd_e           cmd_q, cmd_d;
  logic [BANK_W-1:0] ba_q, ba_d;
  logic [SA_W-1:0]   addr_q, addr_d;
  logic              ack_q, ack_d, oe_q, oe_d, ready_q, ready_d, cke_q;
  logic              we_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] wdata_q;
  logic              lat_en, go;
  int                hold;

  always_comb begin
    state_d   = state_q;
    wcnt_d    = wcnt_q;
    ret_d     = ret_q;
    cmd_d     = CMD_NOP;
    ba_d      = ba_q;
    addr_d    = addr_q;
    ack_d     = 1'b0;
    oe_d      = 1'b0;
    ready_d   = ready_q;
    ref_grant = 1'b0;
    lat_en    = 1'b0;
    go        = 1'b0;
    hold      = 1;
    target    = ST_IDLE;
    case (state_q)
      ST_WAIT: begin
        if (wcnt_q == '0) state_d = ret_q;
        else              wcnt_d  = wcnt_q - 1'b1;
      end
      ST_INIT_PRE: begin
        cmd_d          = CMD_PRE;
        ba_d           = '0;
        addr_d         = '0;
        addr_d[AP_BIT] = 1'b1;
        go = 1'b1; hold = T_RP; target = ST_INIT_REF1;
      end
      ST_INIT_REF1: begin
        cmd_d = CMD_REF;
        go = 1'b1; hold = T_RFC; target = ST_INIT_REF2;
      end
      ST_INIT_REF2: begin
        cmd_d = CMD_REF;
        go = 1'b1; hold = T_RFC; target = ST_INIT_MRS;
      end
      ST_INIT_MRS: begin
        cmd_d   = CMD_MRS;
        ba_d    = '0;
        addr_d  = MODE_WORD;
        ready_d = 1'b1;
        go = 1'b1; hold = T_MRD; target = ST_IDLE;
      end
      ST_IDLE: begin
        if (ref_pending) state_d = ST_REF;
        else if (req)    state_d = ST_ACT;
      end
      ST_REF: begin
        cmd_d     = CMD_REF;
        ref_grant = 1'b1;
        go = 1'b1; hold = T_RFC; target = ST_IDLE;
      end
      ST_ACT: begin
        cmd_d  = CMD_ACT;
        ba_d   = req_addr[ADDR_W-1 -: BANK_W];
        addr_d = req_addr[COL_W +: SA_W];
        lat_en = 1'b1;
        ack_d  = 1'b1;
        go = 1'b1; hold = T_RCD; target = ST_RW;
      end
      ST_RW: begin
        cmd_d              = we_q ? CMD_WR : CMD_RD;
        addr_d             = '0;
        addr_d[COL_W-1:0]  = col_q;
        addr_d[AP_BIT]     = 1'b1;
        oe_d               = we_q;
        go = 1'b1; hold = POST; target = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (go) begin
      if (hold <= 1) begin
        state_d = target;
      end else begin
        state_d = ST_WAIT;
        wcnt_d  = CNT_W'(hold - 2);
        ret_d   = target;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      wcnt_q  <= CNT_W'(T_POWERUP - 2);
      ret_q   <= ST_INIT_PRE;
      cmd_q   <= CMD_NOP;
      ba_q    <= '0;
      addr_q  <= '0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
      ready_q <= 1'b0;
      cke_q   <= 1'b0;
      we_q    <= 1'b0;
      col_q   <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
      ret_q   <= ret_d;
      cmd_q   <= cmd_d;
      ba_q    <= ba_d;
      addr_q  <= addr_d;
      ack_q   <= ack_d;
      oe_q    <= oe_d;
      ready_q <= ready_d;
      cke_q   <= 1'b1;
      if (lat_en) begin
        we_q    <= req_we;
        col_q   <= req_addr[COL_W-1:0];
        wdata_q <= req_wdata;
      end
    end
  end

  assign cmd     = cmd_q;
  assign sd_ba   = ba_q;
  assign sd_addr = addr_q;
  assign ack     = ack_q;
  assign dq_oe   = oe_q;
  assign dq_out  = wdata_q;
  assign ready   = ready_q;
  assign cke     = cke_q;

endmodule

// File: rtl/sdram_lite_ctrl.sv
module sdram_lite_ctrl
  import sdc_pkg::*;
#(
  parameter int BANK_W       = 2,
  parameter int SA_W         = 12,
  parameter int COL_W        = 8,
  parameter int DATA_W       = 16,
  parameter int CAS_LAT      = 2,
  parameter int REG_EXTRA    = 0,
  parameter int T_RCD        = 2,
  parameter int T_RP         = 2,
  parameter int T_WR         = 2,
  parameter int T_RFC        = 7,
  parameter int T_MRD        = 2,
  parameter int T_POWERUP    = 6600,
  parameter int REF_INTERVAL = 500,
  localparam int ADDR_W      = BANK_W + SA_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [SA_W-1:0]   sd_addr,
  output logic [DATA_W-1:0] sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DATA_W-1:0] sd_dq_in
);
  localparam int RET_LAT = CAS_LAT + REG_EXTRA;

  sd_cmd_e cmd;
  logic    ref_pending, ref_grant, ready;

  sdc_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ready),
    .grant   (ref_grant),
    .pending (ref_pending)
  );

  sdc_sequencer #(
    .BANK_W(BANK_W), .SA_W(SA_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .CAS_LAT(CAS_LAT), .REG_EXTRA(REG_EXTRA), .T_RCD(T_RCD), .T_RP(T_RP),
    .T_WR(T_WR), .T_RFC(T_RFC), .T_MRD(T_MRD), .T_POWERUP(T_POWERUP)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .req_we      (req_we),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .ref_pending (ref_pending),
    .ref_grant   (ref_grant),
    .ready       (ready),
    .ack         (ack),
    .cmd         (cmd),
    .sd_ba       (sd_ba),
    .sd_addr     (sd_addr),
    .dq_out      (sd_dq_out),
    .dq_oe       (sd_dq_oe),
    .cke         (sd_cke)
  );

  sdc_read_return #(.DATA_W(DATA_W), .LAT(RET_LAT)) u_ret (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_issued (cmd == CMD_RD),
    .dq_in     (sd_dq_in),
    .rvalid    (rvalid),
    .rdata     (rdata)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

endmodule

// File: rtl/sdc_checker.sv
module sdc_checker
  import sdc_pkg::*;
#(
  parameter int SA_W      = 12,
  parameter int CAS_LAT   = 2,
  parameter int REG_EXTRA = 0,
  parameter int T_RCD     = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ack,
  input logic            rvalid,
  input logic            sd_cs_n,
  input logic            sd_ras_n,
  input logic            sd_cas_n,
  input logic            sd_we_n,
  input logic [SA_W-1:0] sd_addr,
  input logic            sd_dq_oe
);
  localparam int BACK = CAS_LAT + REG_EXTRA + 1;

  logic [3:0] pin_cmd;
  assign pin_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  // R5: acknowledge is a single-cycle pulse
  p_ack_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R5: acknowledge coincides with the row activation on the pins
  p_ack_on_act_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> pin_cmd == 4'(CMD_ACT));

  // R4: column commands always request auto-precharge
  p_rw_autopre_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_cmd == 4'(CMD_RD) || pin_cmd == 4'(CMD_WR)) |-> sd_addr[10]);

  // R4: the cycle after ACT is quiet when the activate delay exceeds one
  if (T_RCD > 1) begin : g_rcd
    p_act_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pin_cmd == 4'(CMD_ACT) |=> pin_cmd == 4'(CMD_NOP));
  end

  // R6: data bus drive only during the WRITE command
  p_oe_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe == (pin_cmd == 4'(CMD_WR)));

  // R7: a read strobe always traces back to a READ at the fixed latency
  p_rvalid_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(pin_cmd == 4'(CMD_RD), BACK));

endmodule

bind sdram_lite_ctrl sdc_checker #(
  .SA_W(SA_W), .CAS_LAT(CAS_LAT), .REG_EXTRA(REG_EXTRA), .T_RCD(T_RCD)
) i_sdc_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .ack      (ack),
  .rvalid   (rvalid),
  .sd_cs_n  (sd_cs_n),
  .sd_ras_n (sd_ras_n),
  .sd_cas_n (sd_cas_n),
  .sd_we_n  (sd_we_n),
  .sd_addr  (sd_addr),
  .sd_dq_oe (sd_dq_oe)
);

// File: tb/test_sdram_lite_ctrl.sv
`timescale 1ns/1ps
module test_sdram_lite_ctrl;
  localparam int BANK_W = 2, SA_W = 12, COL_W = 8, DATA_W = 16;
  localparam int CAS_LAT = 2, REG_EXTRA = 1, T_RCD = 2, T_RP = 2, T_WR = 2;
  localparam int T_RFC = 4, T_MRD = 2, T_POWERUP = 20, REF_INTERVAL = 60;
  localparam int ADDR_W = BANK_W + SA_W + COL_W;
  localparam int LAT = CAS_LAT + REG_EXTRA;
  localparam int POST = T_WR + T_RP + CAS_LAT + REG_EXTRA;
  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
    C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111;

  typedef struct packed {
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } vec_t;

  localparam vec_t VEC [0:7] = '{
    '{1'b1, {2'd1, 12'd3, 8'd5},  16'hA5C3},
    '{1'b1, {2'd2, 12'd0, 8'd15}, 16'h1234},
    '{1'b0, {2'd1, 12'd3, 8'd5},  16'hA5C3},
    '{1'b1, {2'd0, 12'd1, 8'd0},  16'hFFFF},
    '{1'b0, {2'd2, 12'd0, 8'd15}, 16'h1234},
    '{1'b1, {2'd3, 12'd2, 8'd9},  16'h0001},
    '{1'b0, {2'd0, 12'd1, 8'd0},  16'hFFFF},
    '{1'b0, {2'd3, 12'd2, 8'd9},  16'h0001}
  };

  logic clk = 1'b0;
  logic rst_n, req, req_we;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata, rdata, sd_dq_out, sd_dq_in;
  logic ack, rvalid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [BANK_W-1:0] sd_ba;
  logic [SA_W-1:0] sd_addr;

  always #10 clk = ~clk;

  sdram_lite_ctrl #(
    .BANK_W(BANK_W), .SA_W(SA_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .CAS_LAT(CAS_LAT), .REG_EXTRA(REG_EXTRA), .T_RCD(T_RCD), .T_RP(T_RP),
    .T_WR(T_WR), .T_RFC(T_RFC), .T_MRD(T_MRD), .T_POWERUP(T_POWERUP),
    .REF_INTERVAL(REF_INTERVAL)
  ) i_sdram_lite_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack(ack), .rdata(rdata), .rvalid(rvalid),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
    .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
  );

  logic [3:0] pin_cmd;
  assign pin_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  int cyc = 0, checks = 0, errors = 0, rel_cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  // memory model
  logic [DATA_W-1:0] mem [256];
  logic [SA_W-1:0]   open_row [4];
  logic [DATA_W-1:0] mrd [LAT];
  logic              mv  [LAT];
  assign sd_dq_in = mv[LAT-1] ? mrd[LAT-1] : 16'hDEAD;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) mv[i] <= 1'b0;
    end else begin
      if (pin_cmd == C_ACT) open_row[sd_ba] <= sd_addr;
      if (pin_cmd == C_WR)
        mem[{sd_ba, open_row[sd_ba][1:0], sd_addr[3:0]}] <= sd_dq_out;
      mv[0]  <= (pin_cmd == C_RD);
      mrd[0] <= mem[{sd_ba, open_row[sd_ba][1:0], sd_addr[3:0]}];
      for (int i = 1; i < LAT; i++) begin
        mv[i]  <= mv[i-1];
        mrd[i] <= mrd[i-1];
      end
    end
  end

  // command log
  logic [3:0]        log_cmd  [1024];
  int                log_cyc  [1024];
  logic [SA_W-1:0]   log_addr [1024];
  logic [BANK_W-1:0] log_ba   [1024];
  int nlog = 0, nref = 0;
  int ref_cyc [64];

  always @(negedge clk) begin
    if (rst_n && pin_cmd != C_NOP && nlog < 1024) begin
      log_cmd[nlog]  <= pin_cmd;
      log_cyc[nlog]  <= cyc;
      log_addr[nlog] <= sd_addr;
      log_ba[nlog]   <= sd_ba;
      nlog <= nlog + 1;
      if (pin_cmd == C_REF && nref < 64) begin
        ref_cyc[nref] <= cyc;
        nref <= nref + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_to(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic wait_ack(output int a);
    a = -1;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (ack) begin
        a = cyc;
        break;
      end
    end
    chk(a >= 0, "R5 ack seen", 0, 1);
  endtask

  // checks from the ack cycle onward
  task automatic finish_access(input bit we, input logic [ADDR_W-1:0] addr,
                               input logic [DATA_W-1:0] data, input int a);
    chk(pin_cmd == C_ACT, "R5 ack with ACT", pin_cmd, C_ACT);
    chk({sd_ba, sd_addr} == addr[ADDR_W-1:COL_W], "R4 bank/row",
        {sd_ba, sd_addr}, addr[ADDR_W-1:COL_W]);
    @(negedge clk);
    chk(!ack, "R5 ack one cycle", ack, 0);
    wait_to(a + T_RCD);
    chk(pin_cmd == (we ? C_WR : C_RD), "R4 column cmd", pin_cmd, we ? C_WR : C_RD);
    chk(sd_addr[10] && sd_addr[COL_W-1:0] == addr[COL_W-1:0] && sd_ba == addr[ADDR_W-1 -: BANK_W],
        "R4 column/auto-precharge", sd_addr, {1'b1, addr[COL_W-1:0]});
    if (we) begin
      chk(sd_dq_oe && sd_dq_out == data, "R6 write data", sd_dq_out, data);
      @(negedge clk);
      chk(!sd_dq_oe, "R6 drive released", sd_dq_oe, 0);
    end else begin
      wait_to(a + T_RCD + LAT);
      chk(!rvalid, "R7 rvalid not early", rvalid, 0);
      @(negedge clk);
      chk(rvalid && rdata == data, "R7 read data", rdata, data);
      @(negedge clk);
      chk(!rvalid, "R7 rvalid one cycle", rvalid, 0);
    end
  endtask

  task automatic access(input bit we, input logic [ADDR_W-1:0] addr,
                        input logic [DATA_W-1:0] data);
    int a;
    req = 1'b1; req_we = we; req_addr = addr; req_wdata = data;
    wait_ack(a);
    req = 1'b0;
    if (a >= 0) finish_access(we, addr, data, a);
    repeat (POST + 2) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n0, c, tnext, a1, a2, rw_i, bad;
    logic [ADDR_W-1:0] pa;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 4; i++) open_row[i] = '0;
    rst_n = 1'b0; req = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pin_cmd == C_NOP, "R1 NOP in reset", pin_cmd, C_NOP);
    chk({sd_cke, ack, rvalid, sd_dq_oe} == 4'b0, "R1 outputs low in reset",
        {sd_cke, ack, rvalid, sd_dq_oe}, 0);
    rst_n = 1'b1;
    rel_cyc = cyc;
    wait_to(rel_cyc + T_POWERUP + 3 * T_RFC + 10);
    chk(sd_cke, "R1 cke after reset", sd_cke, 1);

    // R2 / R3 initialization
    chk(nlog >= 4, "R2 init commands", nlog, 4);
    chk(log_cmd[0] == C_PRE && log_addr[0][10], "R2 first PRE all", log_cmd[0], C_PRE);
    chk(log_cyc[0] - rel_cyc >= T_POWERUP, "R2 power-up wait",
        log_cyc[0] - rel_cyc, T_POWERUP);
    chk(log_cmd[1] == C_REF && log_cmd[2] == C_REF, "R2 two refreshes",
        {log_cmd[1], log_cmd[2]}, {C_REF, C_REF});
    chk(log_cmd[3] == C_MRS, "R2 mode load", log_cmd[3], C_MRS);
    chk(log_addr[3] == SA_W'(CAS_LAT << 4) && log_ba[3] == '0, "R3 mode word",
        log_addr[3], CAS_LAT << 4);

    // vector table
    for (int v = 0; v < 8; v++) access(VEC[v].we, VEC[v].addr, VEC[v].data);

    // R9 idle refresh spacing
    n0 = nref;
    while (nref < n0 + 3) @(negedge clk);
    chk(ref_cyc[n0+2] - ref_cyc[n0+1] == REF_INTERVAL, "R9 idle refresh period",
        ref_cyc[n0+2] - ref_cyc[n0+1], REF_INTERVAL);

    // R10 refresh falls due during an access, a request waits behind it
    c = ref_cyc[n0+2];
    tnext = c - 3 + REF_INTERVAL;
    pa = {2'd1, 12'd2, 8'd7};
    wait_to(tnext - 4);
    req = 1'b1; req_we = 1'b1; req_addr = pa; req_wdata = 16'hBEEF;
    wait_ack(a1);
    req_we = 1'b0;
    wait_ack(a2);
    req = 1'b0;
    if (a2 >= 0) finish_access(1'b0, pa, 16'hBEEF, a2);
    rw_i = -1;
    for (int i = 0; i < nlog; i++)
      if (log_cyc[i] == a1 + T_RCD) rw_i = i;
    chk(rw_i >= 0 && log_cmd[rw_i+1] == C_REF && log_cmd[rw_i+2] == C_ACT,
        "R10 refresh before waiting request",
        (rw_i >= 0) ? log_cmd[rw_i+1] : 4'hF, C_REF);
    repeat (POST + 2) @(negedge clk);

    // R8 / R11 spacing over the whole log
    bad = 0;
    for (int i = 0; i + 1 < nlog; i++)
      if ((log_cmd[i] == C_RD || log_cmd[i] == C_WR) && log_cyc[i+1] - log_cyc[i] < POST)
        bad++;
    chk(bad == 0, "R8 post-access gap", bad, 0);
    bad = 0;
    for (int i = 0; i + 1 < nlog; i++)
      if (log_cmd[i] == C_REF && log_cyc[i+1] - log_cyc[i] < T_RFC) bad++;
    chk(bad == 0, "R11 refresh gap", bad, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule